// File: doc/BRIEF.md
# Queue Doorbell Counter with Interrupt Status

This block sits at the head of one instruction queue. Software posts work by writing a word count to a doorbell register. The block keeps a 20-bit running total of instruction words that are still pending. On the other side, the instruction fetcher asks for one instruction at a time. The block grants a request only when the queue is switched on and at least one whole instruction (8 words) is pending. Each grant takes 8 words off the total.

The same block holds a seven-bit sticky status register. Its bits are set by one-cycle event pulses: a mailbox strobe from the management side, a carry out of the doorbell adder, and five error sources from the datapath. Software clears status bits by writing ones to them. A separate enable mask, changed through a set register and a clear register, selects which status bits drive the single interrupt line.

If the counter overflows, software recovers it in three steps. It switches the queue off, reads the count, and writes 2^20 minus that value. The sum then wraps to zero. The doorbell-overflow bit is cleared afterwards.

Top module: `qdb_status_top`

## Requirements
- R1: After reset the pending count, the status register, the enable mask and the queue-enable bit are all zero, and `irq_out` is low.
- R2: A write to address 0 adds `reg_wdata` to the pending count modulo 2^20. A read of address 0 returns the pending count.
- R3: If a doorbell add carries past 2^20-1, status bit 1 is set. An add without a carry leaves bit 1 unchanged.
- R4: Writing 2^20 minus the current count to address 0, while no fetch is taken, returns the count to zero.
- R5: Status bit 0 is set by `mbox_wr`. Bit k+2 is set by `err_evt[k]` for k = 0..4: instruction read error, result write error, engine software error, engine hardware error, translation fault. Status reads back at address 1 in bits 6:0.
- R6: A write to address 1 clears each status bit whose `reg_wdata` bit is one. Bits written with zero keep their value.
- R7: A write to address 2 sets the enable bits given by the ones in `reg_wdata[6:0]`. A write to address 3 clears them. Both addresses read back the enable mask.
- R8: `irq_out` is high exactly when some status bit is set and its enable bit is set.
- R9: If an event sets a status bit in the same cycle that a write to address 1 clears it, the bit ends up set.
- R10: `fetch_ack` is high only when `fetch_req` is high, the queue-enable bit (address 4, bit 0) is one, and the count is at least 8. Each acknowledged cycle subtracts 8 from the count.
- R11: A doorbell add and an acknowledged fetch in the same cycle both take effect. The new count is old + add - 8.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| reg_addr | input | 3 | Register select: 0 doorbell, 1 status, 2 enable set, 3 enable clear, 4 queue control |
| reg_wr | input | 1 | Register write strobe |
| reg_wdata | input | 20 | Register write data |
| reg_rdata | output | 20 | Read data for `reg_addr`, combinational |
| mbox_wr | input | 1 | Management-side mailbox write strobe |
| err_evt | input | 5 | One-cycle error event pulses for status bits 2..6 |
| fetch_req | input | 1 | Fetcher asks for one instruction |
| fetch_ack | output | 1 | Instruction granted this cycle |
| irq_out | output | 1 | Interrupt line |

## Verification
The hardest condition to reach from the ports is the doorbell carry. It needs the pending count and the written value to add past 2^20-1. The stimulus gets there by first leaving a small residue after fetches, then writing a value just under 2^20. Recovery is exercised right after: the queue is switched off, the wrapped count is read back, and its complement is written.

Two other cases need precise timing and are driven in a single cycle each: a fetch that coincides with a doorbell add, and an event pulse that coincides with a clear of the same status bit.

// File: rtl/qdb_pkg.sv
package qdb_pkg;

    localparam int QDB_CNT_W   = 20;
    localparam int QDB_INSTR   = 8;
    localparam int QDB_N_STAT  = 7;
    localparam int QDB_N_ERR   = QDB_N_STAT - 2;
    localparam int QDB_ADDR_W  = 3;

    // Status bit positions; software decodes these
    localparam int ST_MBOX = 0;
    localparam int ST_OVF  = 1;
    localparam int ST_ERR0 = 2;

    typedef enum logic [QDB_ADDR_W-1:0] {
        SEL_DBELL = 3'd0,
        SEL_STAT  = 3'd1,
        SEL_ENSET = 3'd2,
        SEL_ENCLR = 3'd3,
        SEL_QCTL  = 3'd4
    } qdb_sel_e;

    typedef struct packed {
        logic                  dbell_wr;
        logic [QDB_N_STAT-1:0] stat_clr;
        logic [QDB_N_STAT-1:0] en_set;
        logic [QDB_N_STAT-1:0] en_clr;
    } qdb_strobe_t;

    // Assemble the per-cycle event vector in status bit order
    function automatic logic [QDB_N_STAT-1:0] qdb_events(
        input logic                 mbox,
        input logic                 ovf,
        input logic [QDB_N_ERR-1:0] errs
    );
        logic [QDB_N_STAT-1:0] v;
        v          = '0;
        v[ST_MBOX] = mbox;
        v[ST_OVF]  = ovf;
        v[QDB_N_STAT-1:ST_ERR0] = errs;
        return v;
    endfunction

endpackage

// File: rtl/qdb_csr.sv
module qdb_csr
    import qdb_pkg::*;
#(
    parameter int CNT_W  = QDB_CNT_W,
    parameter int N_STAT = QDB_N_STAT
) (
    input  logic                  clk,
    input  logic                  rst,
    input  logic [QDB_ADDR_W-1:0] reg_addr,
    input  logic                  reg_wr,
    input  logic [CNT_W-1:0]      reg_wdata,
    input  logic [CNT_W-1:0]      cnt,
    input  logic [N_STAT-1:0]     stat,
    input  logic [N_STAT-1:0]     ena,
    output qdb_strobe_t           strobe,
    output logic                  q_en,
    output logic [CNT_W-1:0]      reg_rdata
);

    qdb_sel_e sel;
    assign sel = qdb_sel_e'(reg_addr);

    always_comb begin
        strobe = '0;
        if (reg_wr) begin
            case (sel)
                SEL_DBELL: strobe.dbell_wr = 1'b1;
                SEL_STAT:  strobe.stat_clr = reg_wdata[N_STAT-1:0];
                SEL_ENSET: strobe.en_set   = reg_wdata[N_STAT-1:0];
                SEL_ENCLR: strobe.en_clr   = reg_wdata[N_STAT-1:0];
                default:   strobe = '0;
            endcase
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            q_en <= 1'b0;
        end else if (reg_wr && sel == SEL_QCTL) begin
            q_en <= reg_wdata[0];
        end
    end

    always_comb begin
        case (sel)
            SEL_DBELL:           reg_rdata = cnt;
            SEL_STAT:            reg_rdata = CNT_W'(stat);
            SEL_ENSET, SEL_ENCLR: reg_rdata = CNT_W'(ena);
            SEL_QCTL:            reg_rdata = CNT_W'(q_en);
            default:             reg_rdata = '0;
        endcase
    end

endmodule

// File: rtl/qdb_counter.sv
module qdb_counter
    import qdb_pkg::*;
#(
    parameter int CNT_W = QDB_CNT_W,
    parameter int INSTR = QDB_INSTR
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             add_en,
    input  logic [CNT_W-1:0] add_val,
    input  logic             q_en,
    input  logic             fetch_req,
    output logic             fetch_ack,
    output logic             ovf_evt,
    output logic [CNT_W-1:0] cnt
);

    localparam logic [CNT_W-1:0] STEP = CNT_W'(INSTR);

    logic [CNT_W:0]   sum_w;
    logic [CNT_W-1:0] addend;
    logic [CNT_W-1:0] cnt_d;

    assign addend    = add_en ? add_val : '0;
    assign sum_w     = {1'b0, cnt} + {1'b0, addend};
    assign fetch_ack = fetch_req && q_en && (cnt >= STEP);
    assign ovf_evt   = add_en && sum_w[CNT_W];
    assign cnt_d     = sum_w[CNT_W-1:0] - (fetch_ack ? STEP : '0);

    always_ff @(posedge clk) begin
        if (rst) cnt <= '0;
        else     cnt <= cnt_d;
    end

endmodule

// File: rtl/qdb_irq_stat.sv
module qdb_irq_stat
    import qdb_pkg::*;
#(
    parameter int N_STAT = QDB_N_STAT
) (
    input  logic              clk,
    input  logic              rst,
    input  logic [N_STAT-1:0] evt,
    input  logic [N_STAT-1:0] stat_clr,
    input  logic [N_STAT-1:0] en_set,
    input  logic [N_STAT-1:0] en_clr,
    output logic [N_STAT-1:0] stat,
    output logic [N_STAT-1:0] ena,
    output logic              irq
);

    for (genvar i = 0; i < N_STAT; i++) begin : g_bit
        // Hardware set takes priority over a software clear
        always_ff @(posedge clk) begin
            if (rst)              stat[i] <= 1'b0;
            else if (evt[i])      stat[i] <= 1'b1;
            else if (stat_clr[i]) stat[i] <= 1'b0;
        end

        always_ff @(posedge clk) begin
            if (rst)            ena[i] <= 1'b0;
            else if (en_set[i]) ena[i] <= 1'b1;
            else if (en_clr[i]) ena[i] <= 1'b0;
        end
    end

    assign irq = |(stat & ena);

endmodule

// File: rtl/qdb_status_top.sv
module qdb_status_top
    import qdb_pkg::*;
#(
    parameter int CNT_W  = QDB_CNT_W,
    parameter int INSTR  = QDB_INSTR,
    parameter int N_STAT = QDB_N_STAT
) (
    input  logic                    clk,
    input  logic                    rst,
    input  logic [QDB_ADDR_W-1:0]   reg_addr,
    input  logic                    reg_wr,
    input  logic [CNT_W-1:0]        reg_wdata,
    output logic [CNT_W-1:0]        reg_rdata,
    input  logic                    mbox_wr,
    input  logic [N_STAT-3:0]       err_evt,
    input  logic                    fetch_req,
    output logic                    fetch_ack,
    output logic                    irq_out
);

    logic [CNT_W-1:0]  pend_cnt;
    logic [N_STAT-1:0] stat_q;
    logic [N_STAT-1:0] ena_q;
    logic [N_STAT-1:0] evt_vec;
    logic              q_en;
    logic              ovf_evt;
    qdb_strobe_t       strobe;

    qdb_csr #(.CNT_W(CNT_W), .N_STAT(N_STAT)) u_csr (
        .clk       (clk),
        .rst       (rst),
        .reg_addr  (reg_addr),
        .reg_wr    (reg_wr),
        .reg_wdata (reg_wdata),
        .cnt       (pend_cnt),
        .stat      (stat_q),
        .ena       (ena_q),
        .strobe    (strobe),
        .q_en      (q_en),
        .reg_rdata (reg_rdata)
    );

    qdb_counter #(.CNT_W(CNT_W), .INSTR(INSTR)) u_cnt (
        .clk       (clk),
        .rst       (rst),
        .add_en    (strobe.dbell_wr),
        .add_val   (reg_wdata),
        .q_en      (q_en),
        .fetch_req (fetch_req),
        .fetch_ack (fetch_ack),
        .ovf_evt   (ovf_evt),
        .cnt       (pend_cnt)
    );

    assign evt_vec = qdb_events(mbox_wr, ovf_evt, err_evt);

    qdb_irq_stat #(.N_STAT(N_STAT)) u_irq (
        .clk      (clk),
        .rst      (rst),
        .evt      (evt_vec),
        .stat_clr (strobe.stat_clr),
        .en_set   (strobe.en_set),
        .en_clr   (strobe.en_clr),
        .stat     (stat_q),
        .ena      (ena_q),
        .irq      (irq_out)
    );

endmodule

// File: rtl/qdb_checker.sv
module qdb_checker
    import qdb_pkg::*;
#(
    parameter int CNT_W  = QDB_CNT_W,
    parameter int N_STAT = QDB_N_STAT
) (
    input logic                  clk,
    input logic                  rst,
    input logic [QDB_ADDR_W-1:0] reg_addr,
    input logic                  reg_wr,
    input logic [CNT_W-1:0]      reg_wdata,
    input logic                  mbox_wr,
    input logic [N_STAT-3:0]     err_evt,
    input logic                  fetch_ack,
    input logic                  irq_out,
    input logic [CNT_W-1:0]      cnt,
    input logic [N_STAT-1:0]     stat,
    input logic [N_STAT-1:0]     ena
);

    localparam logic [CNT_W:0]   WRAP = (CNT_W+1)'(1) << CNT_W;
    localparam logic [CNT_W-1:0] STEP = CNT_W'(QDB_INSTR);

    logic wr_dbell, wr_stat, wr_enset;
    assign wr_dbell = reg_wr && (reg_addr == SEL_DBELL);
    assign wr_stat  = reg_wr && (reg_addr == SEL_STAT);
    assign wr_enset = reg_wr && (reg_addr == SEL_ENSET);

    assert_carry_sets_ovf_R3: assert property (@(posedge clk) disable iff (rst)
        (wr_dbell && (({1'b0, cnt} + {1'b0, reg_wdata}) >= WRAP)) |=> stat[ST_OVF]);

    assert_mbox_sets_R5: assert property (@(posedge clk) disable iff (rst)
        mbox_wr |=> stat[ST_MBOX]);

    assert_err_sets_R5: assert property (@(posedge clk) disable iff (rst)
        (err_evt != '0) |=> ((stat[N_STAT-1:ST_ERR0] & $past(err_evt)) == $past(err_evt)));

    assert_w1c_clears_R6: assert property (@(posedge clk) disable iff (rst)
        (wr_stat && !mbox_wr && err_evt == '0)
        |=> ((stat & $past(reg_wdata[N_STAT-1:0])) == '0));

    assert_set_wins_R9: assert property (@(posedge clk) disable iff (rst)
        (wr_stat && reg_wdata[ST_MBOX] && mbox_wr) |=> stat[ST_MBOX]);

    assert_enset_R7: assert property (@(posedge clk) disable iff (rst)
        wr_enset |=> ((ena & $past(reg_wdata[N_STAT-1:0])) == $past(reg_wdata[N_STAT-1:0])));

    assert_irq_masked_R8: assert property (@(posedge clk) disable iff (rst)
        (ena == '0) |-> !irq_out);

    assert_irq_cause_R8: assert property (@(posedge clk) disable iff (rst)
        irq_out |-> (stat != '0));

    assert_fetch_dec_R10: assert property (@(posedge clk) disable iff (rst)
        (fetch_ack && !wr_dbell) |=> (cnt == $past(cnt) - STEP));

    assert_add_and_fetch_R11: assert property (@(posedge clk) disable iff (rst)
        (fetch_ack && wr_dbell) |=> (cnt == $past(cnt) + $past(reg_wdata) - STEP));

endmodule

bind qdb_status_top qdb_checker #(.CNT_W(CNT_W), .N_STAT(N_STAT)) u_qdb_chk (
    .clk       (clk),
    .rst       (rst),
    .reg_addr  (reg_addr),
    .reg_wr    (reg_wr),
    .reg_wdata (reg_wdata),
    .mbox_wr   (mbox_wr),
    .err_evt   (err_evt),
    .fetch_ack (fetch_ack),
    .irq_out   (irq_out),
    .cnt       (pend_cnt),
    .stat      (stat_q),
    .ena       (ena_q)
);

// File: tb/qdb_status_top_bench.sv
module qdb_status_top_bench;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic [2:0]  reg_addr = '0;
    logic        reg_wr = 1'b0;
    logic [19:0] reg_wdata = '0;
    logic [19:0] reg_rdata;
    logic        mbox_wr = 1'b0;
    logic [4:0]  err_evt = '0;
    logic        fetch_req = 1'b0;
    logic        fetch_ack;
    logic        irq_out;

    always #5 clk = ~clk;

    qdb_status_top u_qdb_status_top (
        .clk       (clk),
        .rst       (rst),
        .reg_addr  (reg_addr),
        .reg_wr    (reg_wr),
        .reg_wdata (reg_wdata),
        .reg_rdata (reg_rdata),
        .mbox_wr   (mbox_wr),
        .err_evt   (err_evt),
        .fetch_req (fetch_req),
        .fetch_ack (fetch_ack),
        .irq_out   (irq_out)
    );

    int tests = 0;
    int fails = 0;
    bit finished = 1'b0;

    // Behavioural reference state
    int       m_cnt;
    bit [6:0] m_stat;
    bit [6:0] m_ena;
    bit       m_qen;

    int last_rd;
    bit last_ack;

    task automatic check(input bit ok, input string req, input int act, input int exp);
        tests++;
        if (!ok) begin
            fails++;
            $display("FAIL %s: actual 0x%0h expected 0x%0h", req, act, exp);
        end
    endtask

    function automatic bit model_ack();
        return fetch_req && m_qen && (m_cnt >= 8);
    endfunction

    function automatic int model_rd();
        case (reg_addr)
            3'd0:       return m_cnt;
            3'd1:       return int'(m_stat);
            3'd2, 3'd3: return int'(m_ena);
            3'd4:       return int'(m_qen);
            default:    return 0;
        endcase
    endfunction

    task automatic model_update();
        int add;
        bit ovf;
        bit ack;
        bit [6:0] clr;
        bit [6:0] setv;
        if (rst) begin
            m_cnt = 0; m_stat = '0; m_ena = '0; m_qen = 1'b0;
            return;
        end
        ack  = model_ack();
        add  = (reg_wr && reg_addr == 3'd0) ? int'(reg_wdata) : 0;
        ovf  = (reg_wr && reg_addr == 3'd0) && (m_cnt + add >= (1 << 20));
        m_cnt = (m_cnt + add - (ack ? 8 : 0)) % (1 << 20);
        clr  = (reg_wr && reg_addr == 3'd1) ? reg_wdata[6:0] : 7'd0;
        setv = {err_evt, ovf, mbox_wr};
        m_stat = (m_stat & ~clr) | setv;
        if (reg_wr && reg_addr == 3'd2) m_ena = m_ena | reg_wdata[6:0];
        if (reg_wr && reg_addr == 3'd3) m_ena = m_ena & ~reg_wdata[6:0];
        if (reg_wr && reg_addr == 3'd4) m_qen = reg_wdata[0];
    endtask

    // One clock: compare combinational outputs, then advance model at the edge
    task automatic step();
        #1;
        if (!rst) begin
            check(fetch_ack == model_ack(), "R10", int'(fetch_ack), int'(model_ack()));
            check(irq_out == |(m_stat & m_ena), "R8", int'(irq_out), int'(|(m_stat & m_ena)));
            check(int'(reg_rdata) == model_rd(), "R2", int'(reg_rdata), model_rd());
        end
        last_rd  = int'(reg_rdata);
        last_ack = fetch_ack;
        @(posedge clk);
        model_update();
        @(negedge clk);
    endtask

    task automatic wr(input logic [2:0] a, input logic [19:0] d);
        reg_addr = a; reg_wr = 1'b1; reg_wdata = d;
        step();
        reg_wr = 1'b0; reg_wdata = '0;
    endtask

    task automatic rd(input logic [2:0] a);
        reg_addr = a; reg_wr = 1'b0;
        step();
    endtask

    initial begin : watchdog
        repeat (200000) @(posedge clk);
        if (!finished) begin
            fails++;
            tests++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("[TB] %0d tests run, %0d failed", tests, fails);
            $finish;
        end
    end

    initial begin : stim
        int acks;
        @(negedge clk);
        repeat (3) step();
        rst = 1'b0;

        // R1: reset state
        rd(3'd0); check(last_rd == 0, "R1", last_rd, 0);
        rd(3'd1); check(last_rd == 0, "R1", last_rd, 0);
        rd(3'd2); check(last_rd == 0, "R1", last_rd, 0);
        rd(3'd4); check(last_rd == 0, "R1", last_rd, 0);
        check(irq_out == 1'b0, "R1", int'(irq_out), 0);

        // R2: accumulation
        wr(3'd0, 20'd16);
        wr(3'd0, 20'd8);
        rd(3'd0); check(last_rd == 24, "R2", last_rd, 24);
        rd(3'd1); check(last_rd == 0, "R3", last_rd, 0);

        // R10: queue disabled, no grant
        fetch_req = 1'b1;
        rd(3'd0); check(last_ack == 1'b0, "R10", int'(last_ack), 0);
        fetch_req = 1'b0;

        // R10: enabled, three grants then none
        wr(3'd4, 20'd1);
        fetch_req = 1'b1;
        acks = 0;
        for (int i = 0; i < 4; i++) begin
            rd(3'd0);
            if (last_ack) acks++;
        end
        fetch_req = 1'b0;
        check(acks == 3, "R10", acks, 3);
        rd(3'd0); check(last_rd == 0, "R10", last_rd, 0);

        // R11: add and fetch in the same cycle
        wr(3'd0, 20'd8);
        fetch_req = 1'b1;
        wr(3'd0, 20'd16);
        check(last_ack == 1'b1, "R11", int'(last_ack), 1);
        fetch_req = 1'b0;
        rd(3'd0); check(last_rd == 16, "R11", last_rd, 16);

        // R3: carry sets overflow bit
        wr(3'd0, 20'hFFFF8);
        rd(3'd0); check(last_rd == 8, "R3", last_rd, 8);
        rd(3'd1); check(last_rd == 'h02, "R3", last_rd, 'h02);

        // R4: recovery by complement
        wr(3'd4, 20'd0);
        rd(3'd0);
        wr(3'd0, 20'((1 << 20) - last_rd));
        rd(3'd0); check(last_rd == 0, "R4", last_rd, 0);

        // R6: clear the overflow bit
        wr(3'd1, 20'h02);
        rd(3'd1); check(last_rd == 0, "R6", last_rd, 0);

        // R5: event sources
        mbox_wr = 1'b1; rd(3'd1); mbox_wr = 1'b0;
        rd(3'd1); check(last_rd == 'h01, "R5", last_rd, 'h01);
        err_evt = 5'b10101; rd(3'd1); err_evt = '0;
        rd(3'd1); check(last_rd == 'h55, "R5", last_rd, 'h55);

        // R6: partial clear keeps zero-written bits
        wr(3'd1, 20'h14);
        rd(3'd1); check(last_rd == 'h41, "R6", last_rd, 'h41);

        // R9: set wins over clear on bit 2
        err_evt = 5'b00001;
        wr(3'd1, 20'h04);
        err_evt = '0;
        rd(3'd1); check(last_rd == 'h45, "R9", last_rd, 'h45);

        // R7 / R8: enable mask and interrupt line
        check(irq_out == 1'b0, "R8", int'(irq_out), 0);
        wr(3'd2, 20'h08);
        rd(3'd2); check(last_rd == 'h08, "R7", last_rd, 'h08);
        check(irq_out == 1'b0, "R8", int'(irq_out), 0);
        wr(3'd2, 20'h40);
        rd(3'd3); check(last_rd == 'h48, "R7", last_rd, 'h48);
        check(irq_out == 1'b1, "R8", int'(irq_out), 1);
        wr(3'd3, 20'h40);
        rd(3'd2); check(last_rd == 'h08, "R7", last_rd, 'h08);
        check(irq_out == 1'b0, "R8", int'(irq_out), 0);
        wr(3'd1, 20'h7F);
        wr(3'd2, 20'h7F);
        rd(3'd1); check(irq_out == 1'b0, "R8", int'(irq_out), 0);
        mbox_wr = 1'b1; rd(3'd1); mbox_wr = 1'b0;
        rd(3'd1); check(irq_out == 1'b1, "R8", int'(irq_out), 1);

        finished = 1'b1;
        $display("[TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end

endmodule